// File: doc/BRIEF.md
# Dual-Mode PWM Generator

This block produces one pulse-width-modulated output from an 8-bit count and an 8-bit duty value. The count can run in one of two ways. In single-slope mode it rises from 0 to 255 and wraps to 0. In dual-slope mode it rises from 0 to 255 and then falls back to 0. The dual-slope period is 510 ticks against 256, so it runs at about half the rate. Its pulses sit symmetrically around the bottom of the count, so their centres are evenly spaced.

A prescale select makes the counter advance on every clock or on every eighth clock. The duty and mode inputs are not used straight away. They are copied into working registers only on the tick that brings the count back to 0, so no period is ever cut short or lengthened part way through. A strobe marks the tick during which the count sits at 0 at the start of each new period.

Top module: `dual_slope_pwm`

## Requirements
- R1: While the synchronous reset is high, and on the cycle after it falls, the output and the strobe are low. The working duty is 0, the working mode is single-slope and the count is 0.
- R2: In single-slope mode the count goes 0, 1, ..., 255, 0, so successive strobes are 256 ticks apart.
- R3: In dual-slope mode the count goes 0, 1, ..., 255, 254, ..., 1, 0, so successive strobes are 510 ticks apart.
- R4: With `divSel` = 0 the counter advances on every clock. With `divSel` = 1 it advances once every 8 clocks, which makes the period 8 times longer.
- R5: A `modeSel` of 2'b01 selects dual-slope mode and 2'b11 selects single-slope mode. The unused codes 2'b00 and 2'b10 also select single-slope mode.
- R6: The output is high exactly while the count is below the working duty. A duty of 0 therefore keeps the output low.
- R7: A working duty of 255 holds the output high for the whole period in both modes.
- R8: In dual-slope mode a duty d between 1 and 254 gives one pulse of 2d-1 ticks, centred on the count-0 tick.
- R9: `duty` and `modeSel` are taken into the working registers only on the tick that moves the count to 0. Changes made at any other time have no effect on the output until then.
- R10: The strobe is high for exactly the one tick during which the count sits at 0 after a wrap. It is not raised for the count of 0 that follows reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| divSel | input | 1 | Prescale select: 0 gives divide by 1, 1 gives divide by 8 |
| modeSel | input | 2 | Counter mode code: 2'b01 dual-slope, any other code single-slope |
| duty | input | 8 | Requested duty value |
| pwmOut | output | 1 | PWM output |
| periodStrobe | output | 1 | High during the count-0 tick that starts each period |

## Verification
The bench builds the block with its default parameters: an 8-bit count and a slow prescale ratio of 8. At these values a single-slope period is 256 clocks at divide by 1, and the longest dual-slope period is 4080 clocks at divide by 8. Many full periods of every mode and prescale pairing therefore fit in one run. Because the parameters are small, random changes to duty, mode and prescale often land in the middle of a period, so the buffering at the wrap point is exercised many times, as are mode switches between unlike periods. The bench also covers the duty extremes 0 and 255 and the unused mode codes.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam logic [1:0] MODE_DUAL = 2'b01;

  typedef struct packed {
    logic tick;   // prescaled advance of the count
    logic load;   // this tick moves the count to 0
  } pwmStrb_t;
endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl import pwm_pkg::*; #(
  parameter int CNT_W   = 8,
  parameter int PRE_DIV = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             divSel,
  input  logic             dualAct,
  output logic [CNT_W-1:0] cnt,
  output pwmStrb_t         strb,
  output logic             periodStrobe
);
  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

  logic [PRE_W-1:0] preCnt;
  logic             countUp;
  logic [CNT_W-1:0] nextCnt;
  logic             nextUp;
  logic             tick;

  assign tick = !divSel || (preCnt == PRE_LAST);

  always_ff @(posedge clk) begin
    if (rst || !divSel) preCnt <= '0;
    else if (preCnt == PRE_LAST) preCnt <= '0;
    else preCnt <= preCnt + 1'b1;
  end

  always_comb begin
    nextCnt = cnt + 1'b1;
    nextUp  = 1'b1;
    if (dualAct) begin
      if (countUp) begin
        if (cnt == CNT_MAX) begin
          nextCnt = CNT_MAX - 1'b1;
          nextUp  = 1'b0;
        end
      end else begin
        nextCnt = cnt - 1'b1;
        nextUp  = (cnt == CNT_W'(1));
      end
    end
  end

  assign strb.tick = tick;
  assign strb.load = tick && (nextCnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt          <= '0;
      countUp      <= 1'b1;
      periodStrobe <= 1'b0;
    end else if (tick) begin
      cnt          <= nextCnt;
      countUp      <= nextUp;
      periodStrobe <= strb.load;
    end
  end

  p_fast_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && !dualAct && cnt == CNT_MAX) |=> (cnt == '0));
  p_dual_turn_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && dualAct && countUp && cnt == CNT_MAX) |=> (cnt == CNT_MAX - 1'b1));
  p_bottom_rises_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) |-> countUp);
  p_slow_spacing_r4: assert property (@(posedge clk) disable iff (rst)
    (divSel && tick) |=> (!tick || !divSel));
  p_strobe_bottom_r10: assert property (@(posedge clk) disable iff (rst)
    periodStrobe |-> (cnt == '0));
endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath import pwm_pkg::*; #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  pwmStrb_t         strb,
  input  logic [1:0]       modeSel,
  input  logic [CNT_W-1:0] duty,
  input  logic [CNT_W-1:0] cnt,
  output logic             dualAct,
  output logic             pwmOut
);
  localparam logic [CNT_W-1:0] DUTY_FULL = {CNT_W{1'b1}};

  logic [CNT_W-1:0] dutyAct;

  always_ff @(posedge clk) begin
    if (rst) begin
      dutyAct <= '0;
      dualAct <= 1'b0;
    end else if (strb.load) begin
      dutyAct <= duty;
      dualAct <= (modeSel == MODE_DUAL);
    end
  end

  assign pwmOut = (dutyAct == DUTY_FULL) || (cnt < dutyAct);

  p_hold_between_r9: assert property (@(posedge clk) disable iff (rst)
    !strb.load |=> ($stable(dutyAct) && $stable(dualAct)));
  p_zero_low_r6: assert property (@(posedge clk) disable iff (rst)
    (dutyAct == '0) |-> !pwmOut);
endmodule

// File: rtl/dual_slope_pwm.sv
module dual_slope_pwm import pwm_pkg::*; #(
  parameter int CNT_W   = 8,
  parameter int PRE_DIV = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             divSel,
  input  logic [1:0]       modeSel,
  input  logic [CNT_W-1:0] duty,
  output logic             pwmOut,
  output logic             periodStrobe
);
  pwmStrb_t         strb;
  logic [CNT_W-1:0] cnt;
  logic             dualAct;

  pwm_ctrl #(.CNT_W(CNT_W), .PRE_DIV(PRE_DIV)) u_ctrl (
    .clk(clk), .rst(rst), .divSel(divSel), .dualAct(dualAct),
    .cnt(cnt), .strb(strb), .periodStrobe(periodStrobe)
  );

  pwm_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .modeSel(modeSel), .duty(duty),
    .cnt(cnt), .dualAct(dualAct), .pwmOut(pwmOut)
  );
endmodule

// File: tb/dual_slope_pwm_test.sv
module dual_slope_pwm_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       divSel = 1'b0;
  logic [1:0] modeSel = 2'b11;
  logic [7:0] duty = 8'd0;
  logic       pwmOut, periodStrobe;

  int vecs = 0;
  int errs = 0;
  int mPre, mPos, mDuty;
  bit mDual, mStrobe;
  longint cyc = 0, lastRise = 0;
  int riseSeen = 0;
  int expPeriod = 0;
  string perTag = "";
  bit prevStrobe = 1'b0;

  always #10 clk = ~clk;

  dual_slope_pwm uut (
    .clk(clk), .rst(rst), .divSel(divSel), .modeSel(modeSel), .duty(duty),
    .pwmOut(pwmOut), .periodStrobe(periodStrobe)
  );

  function automatic int expCount();
    if (mDual && mPos > 255) return 510 - mPos;
    return mPos;
  endfunction

  function automatic bit expPwm();
    return (mDuty == 255) || (expCount() < mDuty);
  endfunction

  task automatic modelStep();
    bit tick;
    int per;
    if (rst) begin
      mPre = 0; mPos = 0; mDual = 0; mDuty = 0; mStrobe = 0;
    end else begin
      tick = !divSel || (mPre == 7);
      mPre = divSel ? (mPre + 1) % 8 : 0;
      if (tick) begin
        per  = mDual ? 510 : 256;
        mPos = (mPos + 1) % per;
        if (mPos == 0) begin
          mDual   = (modeSel == 2'b01);
          mDuty   = duty;
          mStrobe = 1;
        end else mStrobe = 0;
      end
    end
  endtask

  task automatic runCycles(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
      modelStep();
      vecs++;
      if (pwmOut !== expPwm()) begin
        errs++;
        $display("FAIL %s pwmOut cycle %0d: got %b expected %b", tag, cyc, pwmOut, expPwm());
      end
      vecs++;
      if (periodStrobe !== mStrobe) begin   // R10
        errs++;
        $display("FAIL R10 periodStrobe cycle %0d: got %b expected %b", cyc, periodStrobe, mStrobe);
      end
      if (periodStrobe && !prevStrobe) begin
        riseSeen++;
        if (riseSeen >= 3 && expPeriod != 0) begin
          vecs++;
          if (cyc - lastRise != expPeriod) begin
            errs++;
            $display("FAIL %s period: got %0d expected %0d", perTag, cyc - lastRise, expPeriod);
          end
        end
        lastRise = cyc;
      end
      prevStrobe = periodStrobe;
    end
  endtask

  task automatic setSeg(bit d8, logic [1:0] m, logic [7:0] dv, int per, string ptag);
    divSel = d8; modeSel = m; duty = dv;
    expPeriod = per; perTag = ptag; riseSeen = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int segs;
    void'($urandom(32'd20240611));
    runCycles(3, "R1");
    rst = 1'b0;
    runCycles(1, "R1");
    setSeg(1'b0, 2'b11, 8'd0, 256, "R2");
    runCycles(800, "R6");
    setSeg(1'b0, 2'b01, 8'd255, 510, "R3");
    runCycles(1300, "R7");
    setSeg(1'b0, 2'b01, 8'd40, 510, "R3");
    runCycles(1300, "R8");
    setSeg(1'b0, 2'b01, 8'd1, 510, "R3");
    runCycles(1100, "R8");
    setSeg(1'b1, 2'b11, 8'd128, 2048, "R4");
    runCycles(6500, "R4");
    setSeg(1'b0, 2'b00, 8'd90, 256, "R5");
    runCycles(3000, "R5");
    setSeg(1'b0, 2'b10, 8'd200, 256, "R5");
    runCycles(800, "R5");
    setSeg(1'b0, 2'b11, 8'd60, 256, "R2");
    runCycles(900, "R6");
    // R9: change mid-period, old values must hold until the wrap
    runCycles(100, "R9");
    setSeg(1'b0, 2'b01, 8'd200, 0, "R9");
    runCycles(120, "R9");
    runCycles(1200, "R9");
    for (int s = 0; s < 30; s++) begin
      setSeg(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
             8'($urandom_range(0, 255)), 0, "R9");
      if (s % 5 == 0) duty = (s % 10 == 0) ? 8'd255 : 8'd0;
      segs = $urandom_range(100, 2500);
      runCycles(segs, "R9");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule